// File: doc/BRIEF.md
# Candidate Rule Engine Allocator

This block sits behind an intrusion-detection pre-filter. The pre-filter narrows the rule set down to a few candidate rules for each packet. Each candidate index that arrives is bound to its own processing engine, taken from a fixed pool. The allocator gives out the lowest-numbered idle engine. It announces the engine number together with the rule's program identifier, so the engine can load the code for that rule. It keeps one busy bit per engine, and the bit stays set until the engine signals that the packet has ended or that its rule did not match.

A packet can bring more candidates than the pool has engines. The allocator never stalls the stream in that case. The surplus candidates are dropped, and the packet is flagged with its identifier so that a policy stage can decide what happens to it, for example dropping the packet. The flag appears once per packet and clears when the next packet starts.

Top module: `rule_engine_alloc`

## Requirements
- R1: After reset, all busy bits are 0, `asg_valid` is 0 and `ovf_flag` is 0.
- R2: A candidate presented with `cand_valid` in cycle t is granted to the lowest-numbered free engine. In cycle t+1, `asg_valid` is 1, `asg_engine` holds that engine's binary number and `asg_rule` holds the candidate index. An engine counts as free if its busy bit is 0 or if it is being released in cycle t.
- R3: In the cycle where `asg_valid` is 1, the busy bit of `asg_engine` reads 1.
- R4: Setting bit i of `eng_release` in cycle t clears busy bit i in cycle t+1, unless engine i is granted again in cycle t.
- R5: If engine i is released and is also the lowest free engine for a candidate in the same cycle, both actions take effect. The release is applied first, the candidate is granted engine i, and busy bit i stays 1.
- R6: A candidate that arrives while no engine is free produces no assignment and leaves the busy bits unchanged. In the next cycle `ovf_flag` is 1 and `ovf_pkt_id` holds the identifier of the current packet. That identifier is the one latched by the most recent `pkt_start`, or the identifier presented with `pkt_start` in the same cycle.
- R7: Once `ovf_flag` is set, further surplus candidates in the same packet change neither `ovf_flag` nor `ovf_pkt_id`.
- R8: `pkt_start` in cycle t clears `ovf_flag` in cycle t+1. The exception is a candidate in cycle t that itself overflows: it sets the flag again for the new packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_start | input | 1 | First cycle of a new packet |
| pkt_id | input | PKT_W | Packet identifier, sampled with `pkt_start` |
| cand_valid | input | 1 | Candidate rule index present |
| cand_rule | input | RULE_W | Candidate rule / program identifier |
| eng_release | input | ENGINES | Per-engine release (end of packet or mismatch) |
| eng_busy | output | ENGINES | Per-engine busy bits |
| asg_valid | output | 1 | Assignment strobe |
| asg_engine | output | clog2(ENGINES) | Engine granted |
| asg_rule | output | RULE_W | Program identifier pushed to the engine |
| ovf_flag | output | 1 | Packet had more candidates than engines |
| ovf_pkt_id | output | PKT_W | Identifier of the flagged packet |

## Verification
Two kinds of same-cycle event are checked. The first is a release and a grant that land on the same engine. The bench fills the pool, raises one engine's release in the same cycle as a new candidate, and expects that engine to be granted with its busy bit still set. The second is a start of packet that coincides with a candidate. The bench checks that the flag from the old packet clears and that the assignment for the new packet still goes out. A third case takes the pool past full in two packets in a row. The bench expects a single flag per packet, carrying the identifier of the correct packet.

// File: rtl/rule_engine_alloc.sv
module rule_engine_alloc #(
  parameter int ENGINES = 32,
  parameter int RULE_W  = 12,
  parameter int PKT_W   = 8,
  localparam int EW     = (ENGINES > 1) ? $clog2(ENGINES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pkt_start,
  input  logic [PKT_W-1:0]   pkt_id,
  input  logic               cand_valid,
  input  logic [RULE_W-1:0]  cand_rule,
  input  logic [ENGINES-1:0] eng_release,
  output logic [ENGINES-1:0] eng_busy,
  output logic               asg_valid,
  output logic [EW-1:0]      asg_engine,
  output logic [RULE_W-1:0]  asg_rule,
  output logic               ovf_flag,
  output logic [PKT_W-1:0]   ovf_pkt_id
);

  logic [ENGINES-1:0] busy_q;
  logic [ENGINES-1:0] avail;
  logic [ENGINES-1:0] grant;
  logic [EW-1:0]      pick;
  logic [PKT_W-1:0]   cur_id;
  logic               any_free;
  logic               overflow;

  assign avail    = ~busy_q | eng_release;
  assign any_free = |avail;
  assign overflow = cand_valid && !any_free;
  assign eng_busy = busy_q;

  always_comb begin
    pick = '0;
    for (int i = ENGINES - 1; i >= 0; i--)
      if (avail[i]) pick = EW'(i);
  end

  always_comb begin
    grant = '0;
    if (cand_valid && any_free) grant[pick] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= '0;
      asg_valid  <= 1'b0;
      asg_engine <= '0;
      asg_rule   <= '0;
      ovf_flag   <= 1'b0;
      ovf_pkt_id <= '0;
      cur_id     <= '0;
    end else begin
      busy_q    <= (busy_q & ~eng_release) | grant;
      asg_valid <= cand_valid && any_free;
      if (cand_valid && any_free) begin
        asg_engine <= pick;
        asg_rule   <= cand_rule;
      end
      if (pkt_start) cur_id <= pkt_id;
      if (overflow && (pkt_start || !ovf_flag)) begin
        ovf_flag   <= 1'b1;
        ovf_pkt_id <= pkt_start ? pkt_id : cur_id;
      end else if (pkt_start) begin
        ovf_flag <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rule_engine_alloc_chk.sv
module rule_engine_alloc_chk #(
  parameter int ENGINES = 32,
  parameter int RULE_W  = 12,
  parameter int PKT_W   = 8,
  localparam int EW     = (ENGINES > 1) ? $clog2(ENGINES) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pkt_start,
  input logic               cand_valid,
  input logic [ENGINES-1:0] eng_release,
  input logic [ENGINES-1:0] eng_busy,
  input logic               asg_valid,
  input logic [EW-1:0]      asg_engine,
  input logic               ovf_flag,
  input logic [PKT_W-1:0]   ovf_pkt_id
);

  p_asg_from_cand_r2: assert property (@(posedge clk) disable iff (!rst_n)
    asg_valid |-> $past(cand_valid));

  p_busy_with_asg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    asg_valid |-> eng_busy[asg_engine]);

  p_release_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cand_valid && |eng_release) |=> ((eng_busy & $past(eng_release)) == '0));

  p_no_asg_when_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && (&(eng_busy & ~eng_release))) |=> (!asg_valid && ovf_flag));

  p_ovf_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !pkt_start) |=> (ovf_flag && $stable(ovf_pkt_id)));

  p_ovf_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_start && !cand_valid) |=> !ovf_flag);

endmodule

bind rule_engine_alloc rule_engine_alloc_chk #(
  .ENGINES(ENGINES), .RULE_W(RULE_W), .PKT_W(PKT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .cand_valid(cand_valid),
  .eng_release(eng_release), .eng_busy(eng_busy), .asg_valid(asg_valid),
  .asg_engine(asg_engine), .ovf_flag(ovf_flag), .ovf_pkt_id(ovf_pkt_id)
);

// File: tb/rule_engine_alloc_bench.sv
`timescale 1ns/1ps
module rule_engine_alloc_bench;
  localparam int N  = 4;
  localparam int RW = 12;
  localparam int PW = 8;
  localparam int EW = 2;
  localparam int VW = 1 + PW + 1 + RW + N + 1 + EW + N + 1 + PW;
  localparam int NV = 14;

  // st, id, cv, rule, rel, exp_asg, exp_eng, exp_busy, exp_ovf, exp_ovf_id
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 8'd5, 1'b1, 12'd10, 4'b0000, 1'b1, 2'd0, 4'b0001, 1'b0, 8'd0},
    {1'b0, 8'd0, 1'b1, 12'd11, 4'b0000, 1'b1, 2'd1, 4'b0011, 1'b0, 8'd0},
    {1'b0, 8'd0, 1'b1, 12'd12, 4'b0000, 1'b1, 2'd2, 4'b0111, 1'b0, 8'd0},
    {1'b0, 8'd0, 1'b1, 12'd13, 4'b0000, 1'b1, 2'd3, 4'b1111, 1'b0, 8'd0},
    {1'b0, 8'd0, 1'b1, 12'd14, 4'b0000, 1'b0, 2'd0, 4'b1111, 1'b1, 8'd5},
    {1'b0, 8'd0, 1'b1, 12'd15, 4'b0000, 1'b0, 2'd0, 4'b1111, 1'b1, 8'd5},
    {1'b0, 8'd0, 1'b1, 12'd16, 4'b0010, 1'b1, 2'd1, 4'b1111, 1'b1, 8'd5},
    {1'b0, 8'd0, 1'b0, 12'd0,  4'b0101, 1'b0, 2'd0, 4'b1010, 1'b1, 8'd5},
    {1'b0, 8'd0, 1'b1, 12'd17, 4'b0000, 1'b1, 2'd0, 4'b1011, 1'b1, 8'd5},
    {1'b1, 8'd9, 1'b0, 12'd0,  4'b0000, 1'b0, 2'd0, 4'b1011, 1'b0, 8'd0},
    {1'b0, 8'd0, 1'b1, 12'd18, 4'b0000, 1'b1, 2'd2, 4'b1111, 1'b0, 8'd0},
    {1'b0, 8'd0, 1'b1, 12'd19, 4'b0000, 1'b0, 2'd0, 4'b1111, 1'b1, 8'd9},
    {1'b0, 8'd0, 1'b0, 12'd0,  4'b1111, 1'b0, 2'd0, 4'b0000, 1'b1, 8'd9},
    {1'b1, 8'd3, 1'b1, 12'd20, 4'b0000, 1'b1, 2'd0, 4'b0001, 1'b0, 8'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pkt_start = 1'b0;
  logic [PW-1:0] pkt_id = '0;
  logic cand_valid = 1'b0;
  logic [RW-1:0] cand_rule = '0;
  logic [N-1:0] eng_release = '0;
  logic [N-1:0] eng_busy;
  logic asg_valid;
  logic [EW-1:0] asg_engine;
  logic [RW-1:0] asg_rule;
  logic ovf_flag;
  logic [PW-1:0] ovf_pkt_id;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rule_engine_alloc #(.ENGINES(N), .RULE_W(RW), .PKT_W(PW)) u_rule_engine_alloc (
    .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pkt_id(pkt_id),
    .cand_valid(cand_valid), .cand_rule(cand_rule), .eng_release(eng_release),
    .eng_busy(eng_busy), .asg_valid(asg_valid), .asg_engine(asg_engine),
    .asg_rule(asg_rule), .ovf_flag(ovf_flag), .ovf_pkt_id(ovf_pkt_id)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    pkt_start = 1'b0; cand_valid = 1'b0; eng_release = '0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 busy", 32'(eng_busy), 0);
    check("R1 asg_valid", 32'(asg_valid), 0);
    check("R1 ovf_flag", 32'(ovf_flag), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      logic [VW-1:0] v;
      v = VEC[k];
      @(negedge clk);
      pkt_start   = v[VW-1];
      pkt_id      = v[VW-2 -: PW];
      cand_valid  = v[VW-2-PW];
      cand_rule   = v[VW-3-PW -: RW];
      eng_release = v[VW-3-PW-RW -: N];
      @(posedge clk);
      #1;
      idle();
      // R2 grant / R3 busy / R4-R5 release / R6-R8 overflow
      check($sformatf("R2 vec%0d asg_valid", k), 32'(asg_valid), 32'(v[PW+1+N+EW]));
      if (v[PW+1+N+EW]) begin
        check($sformatf("R2 vec%0d asg_engine", k), 32'(asg_engine), 32'(v[PW+1+N+:EW]));
        check($sformatf("R2 vec%0d asg_rule", k), 32'(asg_rule), 32'(v[VW-3-PW -: RW]));
      end
      check($sformatf("R3 R4 R5 vec%0d busy", k), 32'(eng_busy), 32'(v[PW+1+:N]));
      check($sformatf("R6 R7 R8 vec%0d ovf_flag", k), 32'(ovf_flag), 32'(v[PW]));
      if (v[PW])
        check($sformatf("R6 R7 vec%0d ovf_pkt_id", k), 32'(ovf_pkt_id), 32'(v[PW-1:0]));
    end

    // R5: full pool, release engine 2 with a candidate in the same cycle
    @(negedge clk);
    cand_valid = 1'b1; cand_rule = 12'd30;
    @(negedge clk);
    cand_rule = 12'd31;
    @(negedge clk);
    cand_rule = 12'd32;
    @(negedge clk);
    cand_rule = 12'd33; eng_release = 4'b0100;
    @(posedge clk);
    #1;
    idle();
    check("R5 engine", 32'(asg_engine), 2);
    check("R5 busy", 32'(eng_busy), 32'hF);

    // R8: start with an overflowing candidate flags the new packet
    @(negedge clk);
    pkt_start = 1'b1; pkt_id = 8'd77; cand_valid = 1'b1; cand_rule = 12'd40;
    @(posedge clk);
    #1;
    idle();
    check("R8 ovf_flag", 32'(ovf_flag), 1);
    check("R8 ovf_pkt_id", 32'(ovf_pkt_id), 77);
    check("R6 no asg", 32'(asg_valid), 0);

    // R1: reset mid-run clears state
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    check("R1 busy after reset", 32'(eng_busy), 0);
    check("R1 ovf after reset", 32'(ovf_flag), 0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule